// File: doc/BRIEF.md
# Interleaved Scanline-Doubling Video Output

This block turns a slow internal video stream of 8-bit colour indices into a display stream at twice the pixel rate and twice the line count. The index on the input bus is sampled once every `SAMPLE_DIV` clocks. Each sample goes through a 256-entry colour table, and the resulting colour is stored in a line buffer. The line buffer is then replayed twice, on two consecutive output lines, with one output pixel every `OUT_DIV` clocks.

There are two identical lanes, each holding a line buffer. While one lane replays internal line k, the other lane captures internal line k+1. The capture window for line k covers the two output lines just before its first replay. For line 0, those are the last two lines of the previous frame.

In vertical blanking, the colour table is reloaded one entry per beat from a fixed memory region, using a request/valid handshake. At the first clock of every frame, the block latches a prediction of the system-timer value at which the next frame will begin. Pixel sources use this value to stay in step with the frame.

Top module: `scan_doubler`

## Requirements
- R1: While reset is held, `out_de`, `out_rgb`, `mem_req` and `next_frame_time` are all 0.
- R2: An output line lasts `LINE_CLKS` clocks and a frame lasts `FRAME_LINES` lines. Clock 0 after reset is line 0, position 0. The flop outputs show the state of the clock just taken. `out_de` is 1 exactly for positions below `PIX*OUT_DIV` on lines below `2*ACT_LINES`, and `out_rgb` is 0 whenever `out_de` is 0.
- R3: The capture window of internal line k starts at position 0 of output line 2k-2 for k ≥ 1, and of line `FRAME_LINES-2` for k = 0. Pixel i is taken from `vid_idx` on clock window_start+1+i*`SAMPLE_DIV`, and all `PIX` pixels are taken before the window ends.
- R4: Each output pixel equals the colour table entry addressed by all 8 bits of the sampled index, so values 0x00 to 0xFF each select their own entry.
- R5: Internal line k is shown on output lines 2k and 2k+1. Output pixel p (position/`OUT_DIV`) carries captured pixel p. Line k is held in lane k mod 2, with lane 0 taking line 0 of every frame, so capture and replay never use the same lane at the same time.
- R6: A table reload starts at position 0 of line `2*ACT_LINES`. It requests exactly 256 entries at addresses `PAL_BASE`+0 through `PAL_BASE`+255 in ascending order. `mem_req` is low again before line `FRAME_LINES-2` begins.
- R7: `mem_req` stays high with an unchanged `mem_addr` until `mem_valid` is seen. A clock with `mem_valid` high writes `mem_data` into the entry being requested and moves on to the next entry.
- R8: The pixels displayed in frame g use the table loaded during the blanking of frame g-1.
- R9: At the first clock of each frame, `next_frame_time` takes the value `sys_time` + `LINE_CLKS*FRAME_LINES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_idx | input | 8 | Colour index on the internal video bus |
| sys_time | input | TW | Free-running system timer |
| mem_req | output | 1 | Table reload read request |
| mem_addr | output | AW | Address of the requested table entry |
| mem_valid | input | 1 | Read data valid for the pending request |
| mem_data | input | CW | Colour returned by memory |
| out_de | output | 1 | Output pixel valid |
| out_rgb | output | CW | Output colour |
| next_frame_time | output | TW | Predicted timer value at the next frame start |

## Verification
The index bus is driven with a fresh random value on every clock. The exact sampling instant therefore shows up in the output: a sample taken one clock early or late picks a different colour. Forced 0x00 and 0xFF values test the ends of the table address range. A later frame drives a slow counter pattern that repeats across neighbouring clocks, which separates pixel-order faults from timing faults. The memory model returns a different table every frame. Comparing each frame against the table of the frame before it exposes a reload that lands in the wrong frame or at the wrong entry. Checking both replays of every line, frame after frame, catches lane swaps and a single-line replay.

// File: rtl/scan_dbl_pkg.sv
package scan_dbl_pkg;
  // Output pixel index covered by horizontal position h.
  function automatic int unsigned pix_at(input int unsigned h, input int unsigned div);
    return h / div;
  endfunction

  // Clocks in one complete frame.
  function automatic int unsigned frame_clocks(input int unsigned line_clks,
                                               input int unsigned lines);
    return line_clks * lines;
  endfunction
endpackage

// File: rtl/sdbl_timing.sv
module sdbl_timing #(
  parameter int LINE_CLKS   = 5080,
  parameter int FRAME_LINES = 525,
  parameter int ACT_LINES   = 240,
  parameter int PIX         = 240,
  parameter int SAMPLE_DIV  = 16,
  parameter int OUT_DIV     = 8,
  localparam int HW = $clog2(LINE_CLKS),
  localparam int VW = $clog2(FRAME_LINES),
  localparam int PW = $clog2(PIX),
  localparam int DW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          frame_start,
  output logic          reload_start,
  output logic          cap_we,
  output logic          cap_lane,
  output logic [PW-1:0] cap_pix,
  output logic          rd_act,
  output logic          rd_lane,
  output logic [PW-1:0] rd_pix
);
  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic          win_first, win_next, cap_busy;
  logic [DW-1:0] cap_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else if (hpos == HW'(LINE_CLKS - 1)) begin
      hpos <= '0;
      vpos <= (vpos == VW'(FRAME_LINES - 1)) ? '0 : vpos + 1'b1;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  assign frame_start  = (hpos == '0) && (vpos == '0);
  assign reload_start = (hpos == '0) && (vpos == VW'(2 * ACT_LINES));
  assign win_first    = (hpos == '0) && (vpos == VW'(FRAME_LINES - 2));
  assign win_next     = (hpos == '0) && (vpos < VW'(2 * ACT_LINES - 2)) && !vpos[0];

  // Capture side: one window per internal line, lane flips per window.
  assign cap_we = cap_busy && (cap_div == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_busy <= 1'b0;
      cap_div  <= '0;
      cap_pix  <= '0;
      cap_lane <= 1'b0;
    end else if (win_first || win_next) begin
      cap_busy <= 1'b1;
      cap_div  <= '0;
      cap_pix  <= '0;
      cap_lane <= win_first ? 1'b0 : ~cap_lane;
    end else if (cap_busy) begin
      cap_div <= (cap_div == DW'(SAMPLE_DIV - 1)) ? '0 : cap_div + 1'b1;
      if (cap_we) begin
        cap_pix <= cap_pix + 1'b1;
        if (cap_pix == PW'(PIX - 1)) cap_busy <= 1'b0;
      end
    end
  end

  // Replay side: output line pair 2k/2k+1 reads lane k mod 2.
  assign rd_act  = (vpos < VW'(2 * ACT_LINES)) && (hpos < HW'(PIX * OUT_DIV));
  assign rd_lane = vpos[1];
  assign rd_pix  = PW'(scan_dbl_pkg::pix_at(32'(hpos), OUT_DIV));

  assert_cap_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> ({1'b0, cap_pix} < (PW + 1)'(PIX)));
  assert_window_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_first || win_next) |-> !cap_busy);
  assert_rd_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |-> ({1'b0, rd_pix} < (PW + 1)'(PIX)));
endmodule

// File: rtl/sdbl_palette.sv
module sdbl_palette #(
  parameter int CW = 12,
  parameter int AW = 16,
  parameter logic [AW-1:0] PAL_BASE = 16'h7C00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [CW-1:0] mem_data,
  input  logic [7:0]    lk_idx,
  output logic [CW-1:0] lk_color
);
  logic [CW-1:0] tbl [256];
  logic [7:0]    idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && mem_valid) begin
      idx <= idx + 1'b1;
      if (idx == 8'hFF) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (busy && mem_valid) tbl[idx] <= mem_data;
  end

  assign mem_req  = busy;
  assign mem_addr = PAL_BASE + AW'(idx);
  assign lk_color = tbl[lk_idx];

  assert_full_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(idx) == 8'hFF));
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_addr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid && !start) |=> $stable(mem_addr));
endmodule

// File: rtl/sdbl_lane.sv
module sdbl_lane #(
  parameter int PIX = 240,
  parameter int CW  = 12,
  localparam int PW = $clog2(PIX)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] line_mem [PIX];

  always_ff @(posedge clk) begin
    if (we) line_mem[waddr] <= wdata;
  end

  assign rdata = line_mem[raddr];
endmodule

// File: rtl/scan_doubler.sv
module scan_doubler #(
  parameter int LINE_CLKS   = 5080,
  parameter int FRAME_LINES = 525,
  parameter int ACT_LINES   = 240,
  parameter int PIX         = 240,
  parameter int SAMPLE_DIV  = 16,
  parameter int OUT_DIV     = 8,
  parameter int CW          = 12,
  parameter int AW          = 16,
  parameter logic [AW-1:0] PAL_BASE = 16'h7C00,
  parameter int TW          = 32,
  localparam int PW = $clog2(PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    vid_idx,
  input  logic [TW-1:0] sys_time,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [CW-1:0] mem_data,
  output logic          out_de,
  output logic [CW-1:0] out_rgb,
  output logic [TW-1:0] next_frame_time
);
  logic          frame_start, reload_start, pal_busy;
  logic          cap_we, cap_lane, rd_act, rd_lane;
  logic [PW-1:0] cap_pix, rd_pix;
  logic [CW-1:0] cap_color;
  logic [CW-1:0] lane_q [2];

  sdbl_timing #(.LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES), .ACT_LINES(ACT_LINES),
                .PIX(PIX), .SAMPLE_DIV(SAMPLE_DIV), .OUT_DIV(OUT_DIV)) u_timing (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .reload_start(reload_start),
    .cap_we(cap_we), .cap_lane(cap_lane), .cap_pix(cap_pix),
    .rd_act(rd_act), .rd_lane(rd_lane), .rd_pix(rd_pix));

  sdbl_palette #(.CW(CW), .AW(AW), .PAL_BASE(PAL_BASE)) u_pal (
    .clk(clk), .rst_n(rst_n), .start(reload_start), .busy(pal_busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .lk_idx(vid_idx), .lk_color(cap_color));

  for (genvar g = 0; g < 2; g++) begin : g_lane
    sdbl_lane #(.PIX(PIX), .CW(CW)) u_lane (
      .clk(clk), .we(cap_we && (cap_lane == 1'(g))), .waddr(cap_pix), .wdata(cap_color),
      .raddr(rd_pix), .rdata(lane_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_de          <= 1'b0;
      out_rgb         <= '0;
      next_frame_time <= '0;
    end else begin
      out_de  <= rd_act;
      out_rgb <= rd_act ? lane_q[rd_lane] : '0;
      if (frame_start)
        next_frame_time <= sys_time + TW'(scan_dbl_pkg::frame_clocks(LINE_CLKS, FRAME_LINES));
    end
  end

  assert_lane_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_we && rd_act) |-> (cap_lane != rd_lane));
  assert_table_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> !pal_busy);
  assert_blank_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> (out_rgb == '0));
endmodule

// File: tb/tb_scan_doubler.sv
module tb_scan_doubler;
  localparam int LINE = 24, FL = 56, ACT = 4, PIX = 8, SDIV = 4, ODIV = 2;
  localparam int CW = 12, AW = 16, TW = 32;
  localparam logic [AW-1:0] BASE = 16'h7C00;
  localparam int FCLK = LINE * FL;
  localparam int RUNC = 4 * FCLK;
  localparam int OFF  = 32'h1000;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] vid_idx;
  logic [TW-1:0] sys_time;
  logic mem_req, mem_valid;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] mem_data, out_rgb;
  logic out_de;
  logic [TW-1:0] next_frame_time;

  int tests = 0, fails = 0, beats = 0;
  bit done = 1'b0;
  logic [7:0] drv [8192];

  always #5 clk = ~clk;

  scan_doubler #(.LINE_CLKS(LINE), .FRAME_LINES(FL), .ACT_LINES(ACT), .PIX(PIX),
                 .SAMPLE_DIV(SDIV), .OUT_DIV(ODIV), .CW(CW), .AW(AW), .PAL_BASE(BASE),
                 .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .vid_idx(vid_idx), .sys_time(sys_time),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .out_de(out_de), .out_rgb(out_rgb), .next_frame_time(next_frame_time));

  function automatic logic [CW-1:0] palgen(input int f, input int i);
    return CW'(i * 37 + f * 411 + (i ^ f) * 5);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input int n);
    logic [7:0] val;
    if (n % 97 == 5)       val = 8'hFF;
    else if (n % 89 == 3)  val = 8'h00;
    else if (n / FCLK == 3) val = 8'((n / 3) & 8'hFF);
    else                   val = 8'($urandom);
    drv[n % 8192] = val;
    vid_idx  = val;
    sys_time = TW'(n + OFF);
  endtask

  task automatic check_cycle(input int c);
    int g, r, v, h, k, p, ps, sc;
    bit act;
    logic [CW-1:0] exp;
    g = c / FCLK; r = c % FCLK; v = r / LINE; h = r % LINE;
    act = (v < 2 * ACT) && (h < PIX * ODIV);
    chk(out_de == act, "R2 out_de", out_de, act);
    if (!act) chk(out_rgb == '0, "R2 blank rgb", out_rgb, 0);
    else if (g >= 1) begin
      k = v / 2; p = h / ODIV;
      ps = (k == 0) ? g * FCLK - 2 * LINE : g * FCLK + (2 * k - 2) * LINE;
      sc = ps + 1 + p * SDIV;
      exp = palgen(g - 1, int'(drv[sc % 8192]));
      chk(out_rgb == exp, "R3 R4 R5 R8 pixel", out_rgb, exp);
    end
    if (r == 0)
      chk(next_frame_time == TW'(c + OFF + FCLK), "R9 next frame time",
          next_frame_time, c + OFF + FCLK);
    if (v == 2 * ACT && h == 0) beats = 0;
    if (v == FL - 2 && h == 0) begin
      chk(mem_req == 1'b0, "R6 reload finished", mem_req, 0);
      chk(beats == 256, "R6 beat count", beats, 256);
    end
  endtask

  // Memory responder: one outstanding read, valid two negedges later.
  initial begin
    logic [AW-1:0] a;
    int cyc_now;
    mem_valid = 1'b0;
    mem_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        a = mem_addr;
        repeat (2) @(negedge clk);
        chk(mem_addr == a, "R7 request held", mem_addr, a);
        chk(a == BASE + AW'(beats), "R6 address order", a, BASE + AW'(beats));
        cyc_now = $time / 10;
        mem_data  = palgen(cyc_now / FCLK, int'(a - BASE));
        mem_valid = 1'b1;
        beats++;
        @(negedge clk);
        mem_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; vid_idx = '0; sys_time = '0;
    repeat (5) @(negedge clk);
    chk(out_de == 1'b0, "R1 reset out_de", out_de, 0);
    chk(out_rgb == '0, "R1 reset out_rgb", out_rgb, 0);
    chk(mem_req == 1'b0, "R1 reset mem_req", mem_req, 0);
    chk(next_frame_time == '0, "R1 reset next_frame_time", next_frame_time, 0);
    drive(0);
    rst_n = 1'b1;
    for (int c = 0; c < RUNC; c++) begin
      @(negedge clk);
      check_cycle(c);
      drive(c + 1);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule